// File: doc/BRIEF.md
# Redundant Control Word Receiver

This block sits on the receive side of a DC-balanced serial video link. It runs after bit recovery and word alignment. It takes one aligned 20-bit word per cycle, qualified by a valid strobe, and sorts each word into one of four kinds:

- a video word,
- a control word,
- a marker that opens a video phase,
- a marker that closes one.

Video words carry 18 pixel symbols and a polarity flag; the block undoes the polarity inversion. Control words carry nine control bits. Five of them are sent three times each, and the receiver recovers each of those five by majority vote, so a single flipped copy in a field does no harm. The other four control bits travel once.

Each data path keeps its last value while the link carries the other kind of word or a marker. This lets downstream logic read stable sync and colour values across blanking. A data-enable output follows the phase markers. An error pulse reports any control word in which the three copies of a protected field did not all agree, even though the vote has corrected the value.

Top module: `ctrl_word_rx`

## Requirements
- R1: After reset is released, and before any accepted word, vid_o, ctl_o, de_o and err_o are all zero.
- R2: A valid word equal to 0xB5A5F (bit 0 = LSB = first received bit) opens a video phase, and one equal to 0x4A5A1 closes it. These exact matches take priority. Any other word with bit 0 = 1 is video, and any with bit 0 = 0 is control. Marker words change neither vid_o nor ctl_o.
- R3: A video word updates vid_o one clock later. vid_o[i] is word bit i+2 when bit 1 is 0, and the inverse of word bit i+2 when bit 1 is 1.
- R4: vid_o holds its value on every cycle without a valid video word.
- R5: A control word sets ctl_o[k], for k = 0..4, one clock later. The value is the majority of word bits 3k+1, 3k+2 and 3k+3.
- R6: A control word sets ctl_o[5..8] from word bits 16..19, one for one.
- R7: ctl_o holds its value on every cycle without a valid control word.
- R8: de_o rises one clock after a valid video-opening marker and falls one clock after a valid video-closing marker. No other word changes it.
- R9: err_o is high for exactly the one cycle after a valid control word in which some protected field holds copies that are not all equal. It is low otherwise.
- R10: A cycle with valid_i low changes none of vid_o, ctl_o, de_o, whatever word_i carries, and is followed by err_o low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Word clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | word_i holds an aligned word this cycle |
| word_i | input | 20 | Received word, bit 0 first on the line |
| vid_o | output | 18 | Recovered video symbols, held between video words |
| ctl_o | output | 9 | Recovered control bits, held between control words |
| de_o | output | 1 | Recovered data-enable |
| err_o | output | 1 | Pulse: a protected field arrived with disagreeing copies |

## Verification
The bench flips each copy of every protected field in turn. A voter that reads a fixed copy, or weights the copies wrongly, would then pass the flipped bit to ctl_o, and an error flag gated by the wrong field would stay silent. It also sends two flips in one field, where the vote must follow the corrupted majority.

Video words are sent with the polarity flag both set and clear. Marker words are sent between data words, and idle cycles carry stale data on the bus. A design that let a marker fall through as video, inverted on the wrong flag, or let an idle or opposite-phase word touch a held output shows a mismatch on vid_o, ctl_o or de_o in the very next cycle.

// File: rtl/ctrl_rx_pkg.sv
package ctrl_rx_pkg;
  localparam int unsigned VID_W   = 18;
  localparam int unsigned PROT_N  = 5;
  localparam int unsigned COPY_N  = 3;
  localparam int unsigned PLAIN_N = 4;
  localparam int unsigned CTL_W   = PROT_N + PLAIN_N;
  localparam int unsigned WORD_W  = VID_W + 2;

  localparam logic [WORD_W-1:0] OPEN_VID_WORD  = 20'hB5A5F;
  localparam logic [WORD_W-1:0] CLOSE_VID_WORD = 20'h4A5A1;

  typedef enum logic [1:0] {
    K_CTRL   = 2'd0,
    K_VIDEO  = 2'd1,
    K_OPEN   = 2'd2,
    K_CLOSE  = 2'd3
  } word_kind_e;
endpackage

// File: rtl/ctrl_rx_classify.sv
module ctrl_rx_classify
  import ctrl_rx_pkg::*;
#(
  parameter int unsigned              W        = WORD_W,
  parameter logic [W-1:0]             OPEN_W   = OPEN_VID_WORD,
  parameter logic [W-1:0]             CLOSE_W  = CLOSE_VID_WORD
) (
  input  logic [W-1:0] word_i,
  output word_kind_e   kind_o
);
  // markers win over the bit-0 type flag
  always_comb begin
    if (word_i == OPEN_W)       kind_o = K_OPEN;
    else if (word_i == CLOSE_W) kind_o = K_CLOSE;
    else if (word_i[0])         kind_o = K_VIDEO;
    else                        kind_o = K_CTRL;
  end
endmodule

// File: rtl/ctrl_rx_vote.sv
module ctrl_rx_vote #(
  parameter int unsigned COPY_N = 3
) (
  input  logic [COPY_N-1:0] copies_i,
  output logic              bit_o,
  output logic              diff_o
);
  localparam int unsigned HALF = COPY_N / 2;

  always_comb begin
    bit_o  = (int'($countones(copies_i)) > int'(HALF));
    diff_o = (|copies_i) & ~(&copies_i);
  end

  always_comb begin
    if (&copies_i)  assert (bit_o && !diff_o)  else $error("vote unanimous-1 R5");
    if (~|copies_i) assert (!bit_o && !diff_o) else $error("vote unanimous-0 R5");
  end
endmodule

// File: rtl/ctrl_rx_vid.sv
module ctrl_rx_vid #(
  parameter int unsigned VID_W = 18
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             accept_i,
  input  logic             flip_i,
  input  logic [VID_W-1:0] sym_i,
  output logic [VID_W-1:0] vid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       vid_o <= '0;
    else if (accept_i) vid_o <= flip_i ? ~sym_i : sym_i;
  end

  assert_vid_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accept_i |=> $stable(vid_o));
  assert_vid_plain_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_i && !flip_i) |=> vid_o == $past(sym_i));
  assert_vid_inv_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_i && flip_i) |=> vid_o == ~$past(sym_i));
endmodule

// File: rtl/ctrl_rx_ctl.sv
module ctrl_rx_ctl #(
  parameter int unsigned PROT_N  = 5,
  parameter int unsigned COPY_N  = 3,
  parameter int unsigned PLAIN_N = 4
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                accept_i,
  input  logic [PROT_N*COPY_N+PLAIN_N-1:0]    body_i,
  output logic [PROT_N+PLAIN_N-1:0]           ctl_o,
  output logic                                err_o
);
  localparam int unsigned TRIP_W = PROT_N * COPY_N;
  localparam int unsigned CTL_W  = PROT_N + PLAIN_N;

  logic [PROT_N-1:0] voted;
  logic [PROT_N-1:0] diff;
  logic [CTL_W-1:0]  ctl_d;

  for (genvar k = 0; k < PROT_N; k++) begin : g_field
    ctrl_rx_vote #(.COPY_N(COPY_N)) u_vote (
      .copies_i (body_i[k*COPY_N +: COPY_N]),
      .bit_o    (voted[k]),
      .diff_o   (diff[k])
    );
  end

  assign ctl_d = {body_i[TRIP_W +: PLAIN_N], voted};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_o <= '0;
      err_o <= 1'b0;
    end else begin
      err_o <= accept_i && (|diff);
      if (accept_i) ctl_o <= ctl_d;
    end
  end

  assert_ctl_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accept_i |=> $stable(ctl_o));
  assert_ctl_plain_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_i |=> ctl_o[CTL_W-1:PROT_N] == $past(body_i[TRIP_W +: PLAIN_N]));
  assert_err_src_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(accept_i));
endmodule

// File: rtl/ctrl_word_rx.sv
module ctrl_word_rx
  import ctrl_rx_pkg::*;
#(
  parameter int unsigned VID_W   = ctrl_rx_pkg::VID_W,
  parameter int unsigned PROT_N  = ctrl_rx_pkg::PROT_N,
  parameter int unsigned COPY_N  = ctrl_rx_pkg::COPY_N,
  parameter int unsigned PLAIN_N = ctrl_rx_pkg::PLAIN_N
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      valid_i,
  input  logic [VID_W+1:0]          word_i,
  output logic [VID_W-1:0]          vid_o,
  output logic [PROT_N+PLAIN_N-1:0] ctl_o,
  output logic                      de_o,
  output logic                      err_o
);
  // control body (bits 1..) must fill the same word as the video body
  localparam int unsigned W = VID_W + 2;

  word_kind_e kind;
  logic       vid_acc, ctl_acc;

  ctrl_rx_classify #(.W(W)) u_cls (
    .word_i (word_i),
    .kind_o (kind)
  );

  assign vid_acc = valid_i && (kind == K_VIDEO);
  assign ctl_acc = valid_i && (kind == K_CTRL);

  ctrl_rx_vid #(.VID_W(VID_W)) u_vid (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .accept_i (vid_acc),
    .flip_i   (word_i[1]),
    .sym_i    (word_i[W-1:2]),
    .vid_o    (vid_o)
  );

  ctrl_rx_ctl #(.PROT_N(PROT_N), .COPY_N(COPY_N), .PLAIN_N(PLAIN_N)) u_ctl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .accept_i (ctl_acc),
    .body_i   (word_i[W-1:1]),
    .ctl_o    (ctl_o),
    .err_o    (err_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) de_o <= 1'b0;
    else if (valid_i && kind == K_OPEN)  de_o <= 1'b1;
    else if (valid_i && kind == K_CLOSE) de_o <= 1'b0;
  end

  assert_de_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && word_i == OPEN_VID_WORD) |=> de_o);
  assert_de_clr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && word_i == CLOSE_VID_WORD) |=> !de_o);
  assert_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(vid_o) && $stable(ctl_o) && $stable(de_o) && !err_o));
  assert_marker_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (word_i == OPEN_VID_WORD || word_i == CLOSE_VID_WORD))
      |=> ($stable(vid_o) && $stable(ctl_o)));
endmodule

// File: tb/ctrl_word_rx_bench.sv
module ctrl_word_rx_bench;
  localparam logic [19:0] OPEN_W  = 20'hB5A5F;
  localparam logic [19:0] CLOSE_W = 20'h4A5A1;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [19:0] word_i = '0;
  logic [17:0] vid_o;
  logic [8:0]  ctl_o;
  logic        de_o, err_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [17:0] e_vid = '0;
  logic [8:0]  e_ctl = '0;
  logic        e_de  = 1'b0;
  logic        e_err = 1'b0;

  always #4 clk = ~clk;

  ctrl_word_rx u_ctrl_word_rx (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .word_i(word_i),
    .vid_o(vid_o), .ctl_o(ctl_o), .de_o(de_o), .err_o(err_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [19:0] mk_ctl(input logic [8:0] c, input logic [14:0] flips);
    logic [14:0] trip;
    for (int k = 0; k < 5; k++) trip[k*3 +: 3] = {3{c[k]}};
    return {c[8:5], trip ^ flips, 1'b0};
  endfunction

  function automatic logic [19:0] mk_vid(input logic [17:0] s, input logic inv);
    return {s, inv, 1'b1};
  endfunction

  // expected-value model built from the requirements
  task automatic model(input logic v, input logic [19:0] w);
    e_err = 1'b0;
    if (!v) return;                             // R10
    if (w == OPEN_W) e_de = 1'b1;               // R2, R8
    else if (w == CLOSE_W) e_de = 1'b0;
    else if (w[0]) e_vid = w[1] ? ~w[19:2] : w[19:2];   // R3
    else begin
      for (int k = 0; k < 5; k++) begin
        int n;
        n = int'(w[3*k+1]) + int'(w[3*k+2]) + int'(w[3*k+3]);
        e_ctl[k] = (n >= 2);                    // R5
        if (n == 1 || n == 2) e_err = 1'b1;     // R9
      end
      e_ctl[8:5] = w[19:16];                    // R6
    end
  endtask

  task automatic step(input logic v, input logic [19:0] w);
    valid_i = v;
    word_i  = w;
    model(v, w);
    @(negedge clk);
    chk("R3/R4 vid_o", 32'(vid_o), 32'(e_vid));
    chk("R5/R6/R7 ctl_o", 32'(ctl_o), 32'(e_ctl));
    chk("R8 de_o", 32'(de_o), 32'(e_de));
    chk("R9 err_o", 32'(err_o), 32'(e_err));
  endtask

  initial begin
    #800000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1 vid_o", 32'(vid_o), 0);
    chk("R1 ctl_o", 32'(ctl_o), 0);
    chk("R1 de_o", 32'(de_o), 0);
    chk("R1 err_o", 32'(err_o), 0);

    // R3: plain and inverted video
    step(1, mk_vid(18'h2A5C3, 1'b0));
    step(1, mk_vid(18'h2A5C3, 1'b1));
    // R8 / R2: markers move de, leave data alone
    step(1, OPEN_W);
    step(1, mk_vid(18'h0F0F0, 1'b0));
    step(1, CLOSE_W);
    // R6 plain bits, R7 video word leaves ctl_o
    step(1, mk_ctl(9'h1A5, 15'h0));
    step(1, mk_vid(18'h3FFFF, 1'b1));
    // R5 / R9: one flip in every copy of every field
    for (int k = 0; k < 5; k++)
      for (int j = 0; j < 3; j++) begin
        step(1, mk_ctl(9'h0AA, 15'(1) << (3*k + j)));
        step(1, mk_ctl(9'h155, 15'(1) << (3*k + j)));
      end
    // R5: two flips per field overturn the vote
    for (int k = 0; k < 5; k++) step(1, mk_ctl(9'h000, 15'(3) << (3*k)));
    // R4 / R10: idle cycles carry stale words
    step(0, mk_vid(18'h12345, 1'b0));
    step(0, mk_ctl(9'h1FF, 15'h7));
    step(0, OPEN_W);
    step(1, mk_ctl(9'h1FF, 15'h0));
    step(1, CLOSE_W);

    // random mix
    for (int i = 0; i < 2000; i++) begin
      int sel;
      logic [19:0] w;
      sel = int'($urandom_range(0, 9));
      if (sel < 1)       step(0, 20'($urandom));
      else if (sel < 2)  step(1, OPEN_W);
      else if (sel < 3)  step(1, CLOSE_W);
      else if (sel < 6) begin
        w = mk_vid(18'($urandom), 1'($urandom));
        if (w == OPEN_W || w == CLOSE_W) w = w ^ 20'h4;
        step(1, w);
      end else begin
        logic [14:0] f;
        f = ($urandom_range(0, 1) == 0) ? 15'h0 : (15'(1) << $urandom_range(0, 14));
        step(1, mk_ctl(9'($urandom), f));
      end
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule